// File: doc/BRIEF.md
# Multi-Channel Programmable Interval Timer with APB Access

This block is a memory-mapped interval timer that sits on an APB slave port. It has a parameterised number of channels, four by default. Each channel owns a 32-bit down-counter, a reload value and a small control field. The control field picks the tick source and the lane mode. In the wide mode a channel is one 32-bit timer. In the other two modes it splits into two 16-bit timers or four 8-bit timers. Each of these timers counts independently and has its own enable, status and interrupt-enable bit.

Software sets a reload value and a mode, then sets the timer's enable bit. That rising enable loads the counter. On each tick the counter steps down by one. A tick at zero reloads the counter and raises a sticky status bit. Software clears that bit by writing a one to it. The single interrupt line is high whenever some status bit is set and its interrupt-enable bit is also set.

Top module: `apb_interval_timer`

## Requirements
- R1: Every APB access takes one setup and one access cycle, and `pready` stays high. A write takes effect at the clock edge that ends its access cycle. A read of any offset that is not listed in R2 returns zero. The low two address bits are ignored.
- R2: The register map is as follows. Offset 0x00 is a read-only ID that returns 0x54490100. Offset 0x10 is a read-only value that holds the channel count. Offset 0x14 is interrupt enable, 0x18 is interrupt status and 0x1C is timer enable. Each channel c has control at 0x20+0x10*c, reload at 0x24+0x10*c and a read-only counter at 0x28+0x10*c. Control keeps bits [3:0].
- R3: Control bits [2:0] equal to 1 give a single 32-bit timer on enable bit 4*c. Setting a timer's enable bit from 0 to 1 loads its counter from the reload value at that write's edge. While the timer is enabled, each tick decrements the counter. A tick at zero reloads the counter and sets the status bit, so the period is reload+1 ticks.
- R4: Mode value 2 gives two 16-bit timers. Timer i uses reload and counter bits [16*i+15:16*i] and bit 4*c+i in the enable, status and interrupt-enable registers.
- R5: Mode value 3 gives four 8-bit timers. Timer k uses byte k of reload and counter and bit 4*c+k.
- R6: Control bit 3 equal to 1 ticks on every clock. Equal to 0, it ticks once per rising edge of `ext_clk`. That input passes two flip-flops before edge detection.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a set and a clear reach the same bit at the same edge, the set wins.
- R8: `irq` is high exactly when some status bit and its interrupt-enable bit are both 1.
- R9: A reload write to a running timer does not change its counter until that timer's next zero-tick reload. Clearing an enable bit freezes the counter at its present value.
- R10: Mode values 0 and 4 to 7 stop all counting in the channel. Enable bits of timers that the current mode does not use have no effect on any counter or status bit.
- R11: After reset every register and counter reads zero, except the ID and the channel count, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access cycle |
| pready | output | 1 | Always high |
| ext_clk | input | 1 | Slow external tick source |
| irq | output | 1 | Combined masked interrupt |

## Verification
Register writes, counter loads on a rising enable, and counter decrements and reloads on a tick all appear at the edge that ends the cycle in which the cause is present. The bench therefore compares read data in the access cycle, which reflects state from before that edge. An underflow sets its status bit at the same edge as its reload, and `irq` follows status with no further register. For this reason `irq` is compared at every falling clock edge against a behavioural model that is stepped once per rising edge. An external tick acts two clock edges after `ext_clk` rises. The model keeps its own two-stage history of the pin to stay on that schedule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam logic [2:0] MODE_W32 = 3'd1;
   localparam logic [2:0] MODE_W16 = 3'd2;
   localparam logic [2:0] MODE_W8  = 3'd3;

   localparam int CTL_BITS     = 4;
   localparam int CTL_SRC_BIT  = 3;
   localparam int SUBS_PER_CH  = 4;
   localparam int CNT_W        = 32;

   localparam int WORD_ID   = 0;
   localparam int WORD_CFG  = 4;
   localparam int WORD_IEN  = 5;
   localparam int WORD_IST  = 6;
   localparam int WORD_CHEN = 7;
   localparam int WORD_CH0  = 8;

   typedef enum logic [1:0] {
      CR_CTL  = 2'd0,
      CR_REL  = 2'd1,
      CR_CNT  = 2'd2,
      CR_NONE = 2'd3
   } ch_reg_e;

endpackage

// File: rtl/tmr_apb_decode.sv
module tmr_apb_decode
   import tmr_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int ADDR_W   = 8,
   parameter int CH_IDX_W = 2
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit_id,
   output logic                hit_cfg,
   output logic                hit_ien,
   output logic                hit_ist,
   output logic                hit_chen,
   output logic                hit_ch,
   output logic [CH_IDX_W-1:0] ch_idx,
   output ch_reg_e             ch_reg
);
   localparam int WORD_W   = ADDR_W - 2;
   localparam int CH_WORDS = SUBS_PER_CH * NUM_CH;

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] rel_w;
   logic              unused_lo;

   assign word      = addr[ADDR_W-1:2];
   assign unused_lo = ^addr[1:0];
   assign rel_w     = word - WORD_W'(WORD_CH0);

   assign hit_id   = (word == WORD_W'(WORD_ID));
   assign hit_cfg  = (word == WORD_W'(WORD_CFG));
   assign hit_ien  = (word == WORD_W'(WORD_IEN));
   assign hit_ist  = (word == WORD_W'(WORD_IST));
   assign hit_chen = (word == WORD_W'(WORD_CHEN));

   always_comb begin
      hit_ch = (int'(word) >= WORD_CH0) && (int'(word) < WORD_CH0 + CH_WORDS);
      ch_idx = rel_w[CH_IDX_W+1:2];
      if (!hit_ch)
         ch_reg = CR_NONE;
      else
         unique case (rel_w[1:0])
            2'd0:    ch_reg = CR_CTL;
            2'd1:    ch_reg = CR_REL;
            2'd2:    ch_reg = CR_CNT;
            default: ch_reg = CR_NONE;
         endcase
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             mode,
   input  logic                   tick,
   input  logic [SUBS_PER_CH-1:0] en,
   input  logic [SUBS_PER_CH-1:0] start,
   input  logic [CNT_W-1:0]       rel,
   output logic [CNT_W-1:0]       cnt,
   output logic [SUBS_PER_CH-1:0] uf
);
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = cnt;
      uf      = '0;
      unique case (mode)
         MODE_W32: begin
            if (start[0])
               cnt_nxt = rel;
            else if (tick && en[0]) begin
               if (cnt == '0) begin
                  cnt_nxt = rel;
                  uf[0]   = 1'b1;
               end else
                  cnt_nxt = cnt - 32'd1;
            end
         end
         MODE_W16: begin
            for (int i = 0; i < 2; i++) begin
               if (start[i])
                  cnt_nxt[i*16 +: 16] = rel[i*16 +: 16];
               else if (tick && en[i]) begin
                  if (cnt[i*16 +: 16] == 16'd0) begin
                     cnt_nxt[i*16 +: 16] = rel[i*16 +: 16];
                     uf[i] = 1'b1;
                  end else
                     cnt_nxt[i*16 +: 16] = cnt[i*16 +: 16] - 16'd1;
               end
            end
         end
         MODE_W8: begin
            for (int k = 0; k < 4; k++) begin
               if (start[k])
                  cnt_nxt[k*8 +: 8] = rel[k*8 +: 8];
               else if (tick && en[k]) begin
                  if (cnt[k*8 +: 8] == 8'd0) begin
                     cnt_nxt[k*8 +: 8] = rel[k*8 +: 8];
                     uf[k] = 1'b1;
                  end else
                     cnt_nxt[k*8 +: 8] = cnt[k*8 +: 8] - 8'd1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   // R3: a zero-count tick in wide mode brings back the reload value
   a_r3_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_W32 && tick && en[0] && !start[0] && cnt == '0)
      |=> (cnt == $past(rel)));

   // R3: a non-zero count steps down by one per tick
   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_W32 && tick && en[0] && !start[0] && cnt != '0)
      |=> (cnt == $past(cnt) - 32'd1));

   // R9: with nothing enabled or starting, the counter is frozen
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0 && start == '0) |=> $stable(cnt));

   // R10: an unsupported mode neither counts nor flags
   a_r10_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0) |=> $stable(cnt));

endmodule

// File: rtl/apb_interval_timer.sv
module apb_interval_timer
   import tmr_pkg::*;
#(
   parameter int          NUM_CH      = 4,
   parameter int          ADDR_W      = 8,
   parameter logic [31:0] ID_VALUE    = 32'h5449_0100,
   parameter bit          EXT_TICK_EN = 1'b1
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   input  logic              ext_clk,
   output logic              irq
);
   localparam int SUB_W    = SUBS_PER_CH * NUM_CH;
   localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int MAP_END  = 4 * (WORD_CH0 + SUB_W);

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("NUM_CH must lie in 1..8");
   end
   if ((1 << ADDR_W) < MAP_END) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic                hit_id, hit_cfg, hit_ien, hit_ist, hit_chen, hit_ch;
   logic [CH_IDX_W-1:0] ch_idx;
   ch_reg_e             ch_reg;

   tmr_apb_decode #(
      .NUM_CH  (NUM_CH),
      .ADDR_W  (ADDR_W),
      .CH_IDX_W(CH_IDX_W)
   ) u_dec (
      .addr    (paddr),
      .hit_id  (hit_id),
      .hit_cfg (hit_cfg),
      .hit_ien (hit_ien),
      .hit_ist (hit_ist),
      .hit_chen(hit_chen),
      .hit_ch  (hit_ch),
      .ch_idx  (ch_idx),
      .ch_reg  (ch_reg)
   );

   logic wr_en;
   assign wr_en  = psel & penable & pwrite;
   assign pready = 1'b1;

   logic [CTL_BITS-1:0] ctl_q [NUM_CH];
   logic [CNT_W-1:0]    rel_q [NUM_CH];
   logic [CNT_W-1:0]    cnt_w [NUM_CH];
   logic [SUB_W-1:0]    ien_q, ist_q, chen_q;
   logic [SUB_W-1:0]    uf_all, start_all, clr_mask;

   // external tick: variant chosen by parameter
   logic ext_tick;
   if (EXT_TICK_EN) begin : g_ext
      logic ext_q, ext_qq;
      always_ff @(posedge pclk or negedge presetn) begin
         if (!presetn) begin
            ext_q  <= 1'b0;
            ext_qq <= 1'b0;
         end else begin
            ext_q  <= ext_clk;
            ext_qq <= ext_q;
         end
      end
      assign ext_tick = ext_q & ~ext_qq;
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ext_clk;
      assign ext_tick   = 1'b0;
   end

   assign start_all = (wr_en && hit_chen) ? (pwdata[SUB_W-1:0] & ~chen_q) : '0;
   assign clr_mask  = (wr_en && hit_ist)  ? pwdata[SUB_W-1:0] : '0;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic ch_wr;
      logic tick_c;
      assign ch_wr  = wr_en && hit_ch && (int'(ch_idx) == c);
      assign tick_c = ctl_q[c][CTL_SRC_BIT] ? 1'b1 : ext_tick;

      always_ff @(posedge pclk or negedge presetn) begin
         if (!presetn) begin
            ctl_q[c] <= '0;
            rel_q[c] <= '0;
         end else if (ch_wr) begin
            if (ch_reg == CR_CTL) ctl_q[c] <= pwdata[CTL_BITS-1:0];
            if (ch_reg == CR_REL) rel_q[c] <= pwdata;
         end
      end

      tmr_channel u_ch (
         .clk  (pclk),
         .rst_n(presetn),
         .mode (ctl_q[c][2:0]),
         .tick (tick_c),
         .en   (chen_q[c*SUBS_PER_CH +: SUBS_PER_CH]),
         .start(start_all[c*SUBS_PER_CH +: SUBS_PER_CH]),
         .rel  (rel_q[c]),
         .cnt  (cnt_w[c]),
         .uf   (uf_all[c*SUBS_PER_CH +: SUBS_PER_CH])
      );
   end

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         ien_q  <= '0;
         chen_q <= '0;
         ist_q  <= '0;
      end else begin
         if (wr_en && hit_ien)  ien_q  <= pwdata[SUB_W-1:0];
         if (wr_en && hit_chen) chen_q <= pwdata[SUB_W-1:0];
         ist_q <= (ist_q & ~clr_mask) | uf_all;
      end
   end

   assign irq = |(ist_q & ien_q);

   always_comb begin
      prdata = '0;
      if (hit_id)        prdata = ID_VALUE;
      else if (hit_cfg)  prdata = 32'(NUM_CH);
      else if (hit_ien)  prdata = 32'(ien_q);
      else if (hit_ist)  prdata = 32'(ist_q);
      else if (hit_chen) prdata = 32'(chen_q);
      else if (hit_ch) begin
         unique case (ch_reg)
            CR_CTL:  prdata = 32'(ctl_q[ch_idx]);
            CR_REL:  prdata = rel_q[ch_idx];
            CR_CNT:  prdata = cnt_w[ch_idx];
            default: prdata = '0;
         endcase
      end
   end

   // R7: every underflow is visible in status after its edge
   a_r7_set_lands: assert property (@(posedge pclk) disable iff (!presetn)
      (|uf_all) |=> ((ist_q & $past(uf_all)) == $past(uf_all)));

   // R7: status bits drop only where a one was written
   a_r7_sticky: assert property (@(posedge pclk) disable iff (!presetn)
      (|ist_q) |=> ((($past(ist_q) & ~$past(clr_mask)) & ~ist_q) == '0));

   // R8: without any interrupt enable the line stays low
   a_r8_masked: assert property (@(posedge pclk) disable iff (!presetn)
      (ien_q == '0) |-> !irq);

endmodule

// File: tb/sim_apb_interval_timer.sv
module sim_apb_interval_timer;
   localparam int          NCH   = 4;
   localparam int          SUBW  = 4 * NCH;
   localparam logic [31:0] ID_EXP = 32'h5449_0100;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        ext_clk = 1'b0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 pclk = ~pclk;

   apb_interval_timer u0 (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .ext_clk(ext_clk), .irq(irq)
   );

   // behavioural reference model
   logic [31:0]     m_ctl [NCH];
   logic [31:0]     m_rel [NCH];
   logic [31:0]     m_cnt [NCH];
   logic [SUBW-1:0] m_ien, m_ist, m_chen;
   logic            m_eq, m_eqq;
   bit              ext_run = 0;
   int              ext_div = 0;
   string           rd_tag = "R1";

   function automatic logic [31:0] model_read(logic [7:0] a);
      if (a == 8'h00) return ID_EXP;
      if (a == 8'h10) return NCH;
      if (a == 8'h14) return 32'(m_ien);
      if (a == 8'h18) return 32'(m_ist);
      if (a == 8'h1C) return 32'(m_chen);
      if (a >= 8'h20 && int'(a) < 32 + 16 * NCH) begin
         int c = (int'(a) - 32) / 16;
         case (a[3:0])
            4'h0:    return m_ctl[c];
            4'h4:    return m_rel[c];
            4'h8:    return m_cnt[c];
            default: return 32'd0;
         endcase
      end
      return 32'd0;
   endfunction

   task automatic model_edge();
      bit              wr = psel && penable && pwrite;
      bit              etick = m_eq && !m_eqq;
      logic [SUBW-1:0] uf = '0;
      logic [31:0]     nxt [NCH];
      for (int c = 0; c < NCH; c++) begin
         int w, n;
         int mode = int'(m_ctl[c][2:0]);
         bit tk = m_ctl[c][3] ? 1'b1 : etick;
         nxt[c] = m_cnt[c];
         w = (mode == 1) ? 32 : (mode == 2) ? 16 : (mode == 3) ? 8 : 0;
         if (w != 0) begin
            logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
            n = 32 / w;
            for (int i = 0; i < n; i++) begin
               int b = 4 * c + i;
               logic [31:0] f  = (m_cnt[c] >> (i * w)) & mask;
               logic [31:0] rf = (m_rel[c] >> (i * w)) & mask;
               logic [31:0] nf = f;
               bit st = wr && paddr == 8'h1C && pwdata[b] && !m_chen[b];
               if (st) nf = rf;
               else if (m_chen[b] && tk) begin
                  if (f == 0) begin nf = rf; uf[b] = 1'b1; end
                  else nf = (f - 32'd1) & mask;
               end
               nxt[c] = (nxt[c] & ~(mask << (i * w))) | (nf << (i * w));
            end
         end
      end
      for (int c = 0; c < NCH; c++) m_cnt[c] = nxt[c];
      if (wr) begin
         if (paddr == 8'h14) m_ien  = pwdata[SUBW-1:0];
         if (paddr == 8'h1C) m_chen = pwdata[SUBW-1:0];
         if (paddr >= 8'h20 && int'(paddr) < 32 + 16 * NCH) begin
            int c = (int'(paddr) - 32) / 16;
            if (paddr[3:0] == 4'h0) m_ctl[c] = {28'd0, pwdata[3:0]};
            if (paddr[3:0] == 4'h4) m_rel[c] = pwdata;
         end
      end
      m_ist = (m_ist & ~((wr && paddr == 8'h18) ? pwdata[SUBW-1:0] : '0)) | uf;
      m_eqq = m_eq;
      m_eq  = ext_clk;
   endtask

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // one clock: inputs were applied at the falling edge
   task automatic step();
      if (ext_run) begin
         ext_div++;
         if (ext_div == 3) begin ext_div = 0; ext_clk = ~ext_clk; end
      end
      #1;
      if (psel && penable && !pwrite) begin
         logic [31:0] e = model_read(paddr);
         check(prdata === e, rd_tag, prdata, e);
         check(pready === 1'b1, "R1", {31'd0, pready}, 32'd1);
      end
      model_edge();
      @(posedge pclk);
      @(negedge pclk);
      check(irq === |(m_ist & m_ien), "R8", {31'd0, irq}, {31'd0, |(m_ist & m_ien)});
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      step();
      penable = 1;
      step();
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic rd(logic [7:0] a, string tag);
      rd_tag = tag;
      psel = 1; penable = 0; pwrite = 0; paddr = a;
      step();
      penable = 1;
      step();
      psel = 0; penable = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge pclk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin m_ctl[c] = 0; m_rel[c] = 0; m_cnt[c] = 0; end
      m_ien = '0; m_ist = '0; m_chen = '0; m_eq = 0; m_eqq = 0;
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      check(irq === 1'b0, "R11", {31'd0, irq}, 32'd0);

      // R11 / R2 reset values and map; R1 unmapped reads
      rd(8'h00, "R2"); rd(8'h10, "R2");
      rd(8'h14, "R11"); rd(8'h18, "R11"); rd(8'h1C, "R11");
      rd(8'h20, "R11"); rd(8'h24, "R11"); rd(8'h28, "R11");
      rd(8'h04, "R1"); rd(8'h2C, "R1"); rd(8'h60, "R1"); rd(8'hFC, "R1");

      // R3: channel 0 wide timer on clock ticks
      wr(8'h24, 32'd5); wr(8'h20, 32'h9); wr(8'h14, 32'h1);
      rd(8'h24, "R2");
      wr(8'h1C, 32'h1);
      rd(8'h28, "R3");
      for (int i = 0; i < 6; i++) begin idle(i); rd(8'h28, "R3"); end
      rd(8'h18, "R3");
      // R7: zero write has no effect, one clears
      wr(8'h18, 32'h0); rd(8'h18, "R7");
      wr(8'h18, 32'h1); rd(8'h18, "R7");

      // R4: channel 1 split into halves
      wr(8'h34, 32'h0004_0002); wr(8'h30, 32'hA);
      wr(8'h14, 32'h31); wr(8'h1C, 32'h31);
      for (int i = 0; i < 5; i++) begin idle(2); rd(8'h38, "R4"); end
      rd(8'h18, "R4");

      // R5: channel 2 split into bytes
      wr(8'h44, 32'h0403_0201); wr(8'h40, 32'hB); wr(8'h1C, 32'hF31);
      for (int i = 0; i < 6; i++) begin idle(1); rd(8'h48, "R5"); end
      rd(8'h18, "R5");
      wr(8'h18, 32'hFFFF); rd(8'h18, "R7");

      // R6: channel 3 on external ticks
      wr(8'h54, 32'd2); wr(8'h50, 32'h1); wr(8'h1C, 32'h1F31);
      ext_run = 1;
      for (int i = 0; i < 8; i++) begin idle(3); rd(8'h58, "R6"); end
      ext_run = 0;
      rd(8'h18, "R6");

      // R9: reload change while running, then freeze
      wr(8'h24, 32'd9);
      for (int i = 0; i < 6; i++) begin idle(2); rd(8'h28, "R9"); end
      wr(8'h1C, 32'h1F30);
      rd(8'h28, "R9"); idle(7); rd(8'h28, "R9");

      // R10: idle mode and unused enable bits
      wr(8'h40, 32'h8);
      rd(8'h48, "R10"); idle(5); rd(8'h48, "R10");
      wr(8'h18, 32'hFFFF);
      wr(8'h14, 32'hFFFF);
      wr(8'h1C, 32'h0F36);
      idle(12);
      rd(8'h18, "R10"); rd(8'h28, "R10");

      // R3: free-running full-width down count on channel 1
      wr(8'h34, 32'hFFFF_FFFF); wr(8'h30, 32'h9);
      wr(8'h1C, 32'h0F06); wr(8'h1C, 32'h0F16);
      idle(4); rd(8'h38, "R3"); idle(9); rd(8'h38, "R3");

      // R7: status after continued counting, bulk clear
      rd(8'h18, "R7");
      wr(8'h18, 32'hFFFF); rd(8'h18, "R7");
      wr(8'h1C, 32'h0); idle(3); rd(8'h18, "R7");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule